// File: doc/BRIEF.md
# Output Fault Filter and Recovery Controller

This block watches a bank of power output channels and decides, cycle by cycle, which of them must be held off. Each channel delivers raw over-current and open-load comparator flags. The bank as a whole delivers raw supply-overvoltage, supply-undervoltage, temperature-warning and thermal-shutdown flags. Every raw flag passes through a counter-based time filter that runs on a slow tick taken from the system clock. A flag must stay present for its full filter time before it sets a latched status bit. If the flag drops out early, the count starts again from zero.

The per-channel disable outputs feed the output gating. A qualified over-current removes only its own channel. A qualified supply fault or thermal shutdown removes every channel. A channel whose recovery bit is set does not latch off after an over-current. It waits out an off window and then tries again. Under a persistent overload this gives a low-duty soft-start pattern. The off window has one of two lengths, chosen by a duty-select input. A controller clears the status bits with a one-cycle clear strobe. All pins are plain control and status levels, so there is no streaming interface and no back-pressure.

Top module: `fault_supervisor`

## Requirements
- R1: An over-current flag sets its channel's `oc_stat` bit only after it has stayed high for SHORT_TICKS consecutive ticks while the channel is enabled. A dropout of one cycle restarts the count from zero.
- R2: An open-load flag sets `ol_stat` after LONG_TICKS consecutive ticks. Open load never asserts any `ch_dis` bit.
- R3: A qualified over-current with `oc_rec_en` low asserts only that channel's `ch_dis`. The bit stays high, even after the flag goes away, until `clr_stb` is pulsed.
- R4: A qualified over-current with `oc_rec_en` high holds `ch_dis` for exactly OFF_LO_TICKS ticks when `duty_hi`=0, or OFF_HI_TICKS ticks when `duty_hi`=1. It then releases the channel, which trips again after SHORT_TICKS ticks if the fault persists. `oc_stat` stays at 1 throughout.
- R5: If `oc_rec_en` is cleared during an off window, that window still finishes with one more release. The next qualified trip then latches the channel off.
- R6: A supply overvoltage or undervoltage flag that persists for SHORT_TICKS ticks sets `ov_stat` or `uv_stat` and asserts every `ch_dis` bit.
- R7: With `sup_rec_dis`=0, the channels are released automatically once the supply has been fault-free for SHORT_TICKS ticks.
- R8: With `sup_rec_dis`=1, the channels stay disabled after the supply recovers. They are released only by a `clr_stb` that arrives once the supply has been fault-free for the filter time.
- R9: A temperature warning that persists for SHORT_TICKS ticks sets `tw_stat` and changes no `ch_dis` bit. `clr_stb` has no effect on `tw_stat` while the raw warning is still present.
- R10: A qualified thermal shutdown sets `tsd_stat` and asserts every `ch_dis` bit. Both stay set until a `clr_stb` that arrives after the raw flag has gone.
- R11: If `clr_stb` coincides with the cycle in which a fault qualifies, the status bit and its effect on the channel are set, not cleared.
- R12: `any_fault` is 1 exactly when at least one status bit is set.
- R13: After reset, all status bits, `any_fault` and all `ch_dis` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_raw | input | NCH | Raw over-current flag per channel |
| ol_raw | input | NCH | Raw open-load flag per channel |
| ov_raw | input | 1 | Raw supply overvoltage flag |
| uv_raw | input | 1 | Raw supply undervoltage flag |
| tw_raw | input | 1 | Raw temperature warning flag |
| tsd_raw | input | 1 | Raw thermal shutdown flag |
| oc_rec_en | input | NCH | Automatic over-current retry enable per channel |
| duty_hi | input | 1 | 1 selects the short off window (higher retry duty) |
| sup_rec_dis | input | 1 | 1 holds supply-fault shutdown until a clear |
| clr_stb | input | 1 | One-cycle status clear request |
| ch_dis | output | NCH | Per-channel disable to the output gating |
| oc_stat | output | NCH | Latched over-current status |
| ol_stat | output | NCH | Latched open-load status |
| ov_stat | output | 1 | Latched overvoltage status |
| uv_stat | output | 1 | Latched undervoltage status |
| tw_stat | output | 1 | Latched temperature warning |
| tsd_stat | output | 1 | Latched thermal shutdown |
| any_fault | output | 1 | OR of all status bits |

## Verification
The embedded properties check, on every cycle, that a filter event never comes from a single-cycle flag. They also check that a latched channel or supply hold persists until a clear, that thermal status survives a clear while its raw flag is present, and that a qualifying event always leaves its status bit set even when a clear is pending. The bench scenarios show the timing itself: the filter windows, the exact off and on lengths of the retry pattern at both duty settings, and the single extra retry after the recovery bit drops. They also show the difference between automatic and held supply recovery, and that status bits which are informational only never touch the disables.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef struct packed {
    logic ov;
    logic uv;
    logic tw;
    logic tsd;
  } glob_stat_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fsup_tick.sv
module fsup_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      logic t_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) t_q <= 1'b0;
        else        t_q <= 1'b1;
      assign tick = t_q;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/fsup_filt.sv
module fsup_filt #(
  parameter int THRESH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic evt
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] TOP  = CW'(THRESH);
  localparam logic [CW-1:0] TOPM = CW'(THRESH - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   cnt <= '0;
    else if (!raw)                cnt <= '0;
    else if (tick && cnt != TOP)  cnt <= cnt + 1'b1;

  assign evt = raw & tick & (cnt == TOPM);

  generate
    if (THRESH > 1) begin : g_chk
      AST_EVT_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $past(raw)); // R1
    end
  endgenerate
endmodule

// File: rtl/fsup_chan.sv
module fsup_chan #(
  parameter int SHORT_TICKS  = 32,
  parameter int LONG_TICKS   = 1000,
  parameter int OFF_LO_TICKS = 224,
  parameter int OFF_HI_TICKS = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic oc_raw,
  input  logic ol_raw,
  input  logic rec_en,
  input  logic duty_hi,
  input  logic gl_off,
  input  logic clr,
  output logic dis,
  output logic oc_stat,
  output logic ol_stat
);
  import fsup_pkg::*;
  localparam int OFF_MAX = imax(OFF_LO_TICKS, OFF_HI_TICKS);
  localparam int OW = $clog2(OFF_MAX + 1);

  logic lock, retry;
  logic [OW-1:0] off_cnt;
  logic oc_evt, ol_evt;

  assign dis = lock | retry | gl_off;

  fsup_filt #(.THRESH(SHORT_TICKS)) u_oc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(oc_raw & ~dis), .evt(oc_evt));
  fsup_filt #(.THRESH(LONG_TICKS)) u_ol (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(ol_raw & ~dis), .evt(ol_evt));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      oc_stat <= 1'b0;
      ol_stat <= 1'b0;
      lock    <= 1'b0;
      retry   <= 1'b0;
      off_cnt <= '0;
    end else begin
      if (oc_evt)   oc_stat <= 1'b1;
      else if (clr) oc_stat <= 1'b0;
      if (ol_evt)   ol_stat <= 1'b1;
      else if (clr) ol_stat <= 1'b0;
      if (oc_evt && !rec_en) lock <= 1'b1;
      else if (clr)          lock <= 1'b0;
      if (oc_evt && rec_en) begin
        retry   <= 1'b1;
        off_cnt <= duty_hi ? OW'(OFF_HI_TICKS) : OW'(OFF_LO_TICKS);
      end else if (retry && tick) begin
        if (off_cnt <= OW'(1)) retry <= 1'b0;
        else                   off_cnt <= off_cnt - 1'b1;
      end
    end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    lock && !clr |=> lock && dis); // R3
  AST_RETRY_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(retry) && !$past(clr) |-> oc_stat); // R4
  AST_OC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    oc_evt |=> oc_stat && dis); // R11
endmodule

// File: rtl/fsup_glob.sv
module fsup_glob #(
  parameter int SHORT_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ov_raw,
  input  logic uv_raw,
  input  logic tw_raw,
  input  logic tsd_raw,
  input  logic sup_rec_dis,
  input  logic clr,
  output fsup_pkg::glob_stat_t st,
  output logic gl_off
);
  logic ov_evt, uv_evt, tw_evt, tsd_evt, good_evt;
  logic sup_bad, good_ok;
  logic sup_fault;

  assign sup_fault = ov_raw | uv_raw;

  fsup_filt #(.THRESH(SHORT_TICKS)) u_ov (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(ov_raw), .evt(ov_evt));
  fsup_filt #(.THRESH(SHORT_TICKS)) u_uv (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(uv_raw), .evt(uv_evt));
  fsup_filt #(.THRESH(SHORT_TICKS)) u_good (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(~sup_fault), .evt(good_evt));
  fsup_filt #(.THRESH(SHORT_TICKS)) u_tw (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(tw_raw), .evt(tw_evt));
  fsup_filt #(.THRESH(SHORT_TICKS)) u_tsd (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(tsd_raw), .evt(tsd_evt));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= '0;
      sup_bad <= 1'b0;
      good_ok <= 1'b0;
    end else begin
      if (ov_evt)   st.ov <= 1'b1;
      else if (clr) st.ov <= 1'b0;
      if (uv_evt)   st.uv <= 1'b1;
      else if (clr) st.uv <= 1'b0;
      if (tw_evt)                 st.tw <= 1'b1;
      else if (clr && !tw_raw)    st.tw <= 1'b0;
      if (tsd_evt)                st.tsd <= 1'b1;
      else if (clr && !tsd_raw)   st.tsd <= 1'b0;
      if (sup_fault)     good_ok <= 1'b0;
      else if (good_evt) good_ok <= 1'b1;
      if (ov_evt || uv_evt)                             sup_bad <= 1'b1;
      else if (sup_bad && good_ok && (!sup_rec_dis || clr)) sup_bad <= 1'b0;
    end

  assign gl_off = sup_bad | st.tsd;

  AST_SUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sup_bad && sup_rec_dis && !clr |=> sup_bad); // R8
  AST_TW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    st.tw && tw_raw |=> st.tw); // R9
  AST_TSD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    st.tsd && tsd_raw |=> st.tsd && gl_off); // R10
  AST_SUP_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ov_evt || uv_evt |=> gl_off); // R11
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int NCH          = 6,
  parameter int TICK_DIV     = 100,
  parameter int SHORT_TICKS  = 32,
  parameter int LONG_TICKS   = 1000,
  parameter int OFF_LO_TICKS = 224,
  parameter int OFF_HI_TICKS = 96
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] oc_raw,
  input  logic [NCH-1:0] ol_raw,
  input  logic           ov_raw,
  input  logic           uv_raw,
  input  logic           tw_raw,
  input  logic           tsd_raw,
  input  logic [NCH-1:0] oc_rec_en,
  input  logic           duty_hi,
  input  logic           sup_rec_dis,
  input  logic           clr_stb,
  output logic [NCH-1:0] ch_dis,
  output logic [NCH-1:0] oc_stat,
  output logic [NCH-1:0] ol_stat,
  output logic           ov_stat,
  output logic           uv_stat,
  output logic           tw_stat,
  output logic           tsd_stat,
  output logic           any_fault
);
  import fsup_pkg::*;

  logic       tick;
  logic       gl_off;
  glob_stat_t gst;

  fsup_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  fsup_glob #(.SHORT_TICKS(SHORT_TICKS)) u_glob (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ov_raw(ov_raw), .uv_raw(uv_raw), .tw_raw(tw_raw), .tsd_raw(tsd_raw),
    .sup_rec_dis(sup_rec_dis), .clr(clr_stb), .st(gst), .gl_off(gl_off));

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      fsup_chan #(
        .SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS),
        .OFF_LO_TICKS(OFF_LO_TICKS), .OFF_HI_TICKS(OFF_HI_TICKS)
      ) u_ch (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .oc_raw(oc_raw[i]), .ol_raw(ol_raw[i]), .rec_en(oc_rec_en[i]),
        .duty_hi(duty_hi), .gl_off(gl_off), .clr(clr_stb),
        .dis(ch_dis[i]), .oc_stat(oc_stat[i]), .ol_stat(ol_stat[i]));
    end
  endgenerate

  assign ov_stat   = gst.ov;
  assign uv_stat   = gst.uv;
  assign tw_stat   = gst.tw;
  assign tsd_stat  = gst.tsd;
  assign any_fault = (|oc_stat) | (|ol_stat) | gst.ov | gst.uv | gst.tw | gst.tsd;

  AST_SHUTDOWN_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tsd_stat) |-> &ch_dis); // R10
  AST_FAULT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tsd_stat) || $rose(ov_stat) |-> any_fault); // R12
endmodule

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
  localparam int N  = 3;
  localparam int D  = 4;
  localparam int S  = 4;
  localparam int L  = 12;
  localparam int OL = 28;
  localparam int OH = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] oc_raw = '0, ol_raw = '0, oc_rec_en = '0;
  logic ov_raw = 0, uv_raw = 0, tw_raw = 0, tsd_raw = 0;
  logic duty_hi = 0, sup_rec_dis = 0, clr_stb = 0;
  logic [N-1:0] ch_dis, oc_stat, ol_stat;
  logic ov_stat, uv_stat, tw_stat, tsd_stat, any_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fault_supervisor #(
    .NCH(N), .TICK_DIV(D), .SHORT_TICKS(S), .LONG_TICKS(L),
    .OFF_LO_TICKS(OL), .OFF_HI_TICKS(OH)
  ) i_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .ol_raw(ol_raw),
    .ov_raw(ov_raw), .uv_raw(uv_raw), .tw_raw(tw_raw), .tsd_raw(tsd_raw),
    .oc_rec_en(oc_rec_en), .duty_hi(duty_hi), .sup_rec_dis(sup_rec_dis),
    .clr_stb(clr_stb), .ch_dis(ch_dis), .oc_stat(oc_stat), .ol_stat(ol_stat),
    .ov_stat(ov_stat), .uv_stat(uv_stat), .tw_stat(tw_stat),
    .tsd_stat(tsd_stat), .any_fault(any_fault));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_pulse();
    clr_stb = 1'b1;
    wn(1);
    clr_stb = 1'b0;
    wn(1);
  endtask

  task automatic wait_high(input int ch, input int lim);
    for (int k = 0; k < lim && !ch_dis[ch]; k++) wn(1);
  endtask

  task automatic t_reset();
    chk(ch_dis == '0, "R13", "ch_dis after reset", ch_dis, 0);
    chk(any_fault == 1'b0, "R13", "any_fault after reset", any_fault, 0);
    chk(oc_stat == '0 && ol_stat == '0, "R13", "channel status after reset",
        {oc_stat, ol_stat}, 0);
  endtask

  task automatic t_oc_latch();
    oc_raw[0] = 1'b1; wn((S-1)*D-2);
    oc_raw[0] = 1'b0; wn(1);
    oc_raw[0] = 1'b1; wn((S-1)*D-2);
    oc_raw[0] = 1'b0; wn(1);
    chk(oc_stat[0] == 1'b0, "R1", "oc_stat after broken flag", oc_stat[0], 0);
    oc_raw[0] = 1'b1; wn((S-1)*D-1);
    chk(oc_stat[0] == 1'b0, "R1", "oc_stat before filter time", oc_stat[0], 0);
    wn(D+4);
    chk(oc_stat[0] == 1'b1, "R1", "oc_stat after filter time", oc_stat[0], 1);
    chk(ch_dis == 3'b001, "R3", "only tripped channel off", ch_dis, 1);
    chk(any_fault == 1'b1, "R12", "any_fault with oc", any_fault, 1);
    oc_raw[0] = 1'b0; wn(5*S*D);
    chk(ch_dis[0] == 1'b1, "R3", "channel held off without clear", ch_dis[0], 1);
    clear_pulse();
    chk(ch_dis == '0, "R3", "channel released by clear", ch_dis, 0);
    chk(any_fault == 1'b0, "R12", "any_fault after clear", any_fault, 0);
  endtask

  task automatic t_ol();
    ol_raw[1] = 1'b1; wn((L-1)*D-1);
    chk(ol_stat[1] == 1'b0, "R2", "ol_stat before long filter", ol_stat[1], 0);
    wn(D+4);
    chk(ol_stat[1] == 1'b1, "R2", "ol_stat after long filter", ol_stat[1], 1);
    chk(ch_dis == '0, "R2", "open load disables nothing", ch_dis, 0);
    ol_raw[1] = 1'b0;
    clear_pulse();
    chk(ol_stat == '0, "R2", "ol_stat cleared", ol_stat, 0);
  endtask

  task automatic t_retry(input bit dh);
    int hi, lo, exp_hi;
    exp_hi = (dh ? OH : OL) * D;
    duty_hi = dh; oc_rec_en[1] = 1'b1; oc_raw[1] = 1'b1;
    wait_high(1, 4*S*D);
    hi = 0;
    while (ch_dis[1] && hi < 4000) begin hi++; wn(1); end
    lo = 0;
    while (!ch_dis[1] && lo < 4000) begin lo++; wn(1); end
    chk(hi >= exp_hi-1 && hi <= exp_hi+1, "R4", "retry off length", hi, exp_hi);
    chk(lo >= S*D-1 && lo <= S*D+1, "R4", "retry on length", lo, S*D);
    chk(oc_stat[1] == 1'b1, "R4", "oc_stat stays set while retrying", oc_stat[1], 1);
    oc_raw[1] = 1'b0;
    for (int k = 0; k < 4000 && ch_dis[1]; k++) wn(1);
    oc_rec_en[1] = 1'b0; duty_hi = 1'b0;
    clear_pulse();
  endtask

  task automatic t_extra();
    oc_rec_en[2] = 1'b1; oc_raw[2] = 1'b1;
    wait_high(2, 4*S*D);
    wn(2);
    oc_rec_en[2] = 1'b0;
    for (int k = 0; k < OL*D+4 && ch_dis[2]; k++) wn(1);
    chk(ch_dis[2] == 1'b0, "R5", "one more release after recovery cleared", ch_dis[2], 0);
    wait_high(2, S*D+4);
    wn(3*OL*D);
    chk(ch_dis[2] == 1'b1, "R5", "latched after extra retry", ch_dis[2], 1);
    oc_raw[2] = 1'b0;
    clear_pulse();
    chk(ch_dis[2] == 1'b0, "R5", "released after clear", ch_dis[2], 0);
  endtask

  task automatic t_sup_auto();
    ov_raw = 1'b1; wn((S-1)*D-1);
    chk(ch_dis == '0, "R6", "outputs on before ov filter", ch_dis, 0);
    wn(D+4);
    chk(ch_dis == '1, "R6", "all outputs off on ov", ch_dis, 7);
    chk(ov_stat == 1'b1, "R6", "ov_stat set", ov_stat, 1);
    ov_raw = 1'b0; wn((S-1)*D-1);
    chk(ch_dis == '1, "R7", "still off before good filter", ch_dis, 7);
    wn(D+4);
    chk(ch_dis == '0, "R7", "auto resume after supply good", ch_dis, 0);
    chk(ov_stat == 1'b1, "R7", "ov_stat kept after resume", ov_stat, 1);
    clear_pulse();
    chk(ov_stat == 1'b0, "R7", "ov_stat cleared", ov_stat, 0);
  endtask

  task automatic t_sup_hold();
    sup_rec_dis = 1'b1; uv_raw = 1'b1; wn(S*D+4);
    chk(ch_dis == '1 && uv_stat, "R6", "uv disables all", {uv_stat, ch_dis}, 15);
    uv_raw = 1'b0; wn(3*S*D);
    chk(ch_dis == '1, "R8", "held off after supply good", ch_dis, 7);
    clear_pulse();
    chk(ch_dis == '0, "R8", "released by clear", ch_dis, 0);
    chk(uv_stat == 1'b0, "R8", "uv_stat cleared", uv_stat, 0);
    sup_rec_dis = 1'b0;
  endtask

  task automatic t_thermal();
    tw_raw = 1'b1; wn(S*D+4);
    chk(tw_stat == 1'b1, "R9", "tw_stat set", tw_stat, 1);
    chk(ch_dis == '0, "R9", "warning changes no output", ch_dis, 0);
    clear_pulse();
    chk(tw_stat == 1'b1, "R9", "clear ignored while warning present", tw_stat, 1);
    tw_raw = 1'b0; wn(2);
    clear_pulse();
    chk(tw_stat == 1'b0, "R9", "tw_stat cleared after condition gone", tw_stat, 0);
    tsd_raw = 1'b1; wn(S*D+4);
    chk(ch_dis == '1 && tsd_stat, "R10", "shutdown disables all", {tsd_stat, ch_dis}, 15);
    clear_pulse();
    chk(ch_dis == '1, "R10", "clear ignored while shutdown present", ch_dis, 7);
    tsd_raw = 1'b0; wn(3*S*D);
    chk(ch_dis == '1, "R10", "shutdown stays latched", ch_dis, 7);
    clear_pulse();
    chk(ch_dis == '0 && !tsd_stat, "R10", "resume after clear", {tsd_stat, ch_dis}, 0);
    chk(any_fault == 1'b0, "R12", "any_fault all clear", any_fault, 0);
  endtask

  task automatic t_race();
    int seen = 0;
    clr_stb = 1'b1; oc_raw[0] = 1'b1;
    for (int k = 0; k < 6*S*D; k++) begin
      wn(1);
      if (ch_dis[0]) seen++;
    end
    chk(seen > 0, "R11", "trip survives coincident clear", seen, 1);
    oc_raw[0] = 1'b0; wn(1);
    clr_stb = 1'b0; wn(2);
    chk(ch_dis[0] == 1'b0 && !any_fault, "R11", "cleared afterwards",
        {any_fault, ch_dis[0]}, 0);
  endtask

  initial begin
    wn(3);
    rst_n = 1'b1;
    wn(2);
    t_reset();
    t_oc_latch();
    t_ol();
    t_retry(1'b0);
    t_retry(1'b1);
    t_extra();
    t_sup_auto();
    t_sup_hold();
    t_thermal();
    t_race();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule